// File: doc/BRIEF.md
# Input Conditioner: Synchronizer, Debounce Filter and Edge Strobes

This block takes one asynchronous external signal, such as a push button, a slide switch or a serial pin, and makes it safe to use inside a single system clock domain. The raw signal first passes through a chain of flip-flops that brings it into the clock domain. A debounce filter follows. It moves its conditioned level to a new value only after the synchronized signal has held that value for a programmable number of consecutive clock cycles. Shorter excursions, such as contact bounce or electrical glitches, are discarded.

Two strobes are derived from the conditioned level, one for a rising transition and one for a falling transition. Each strobe is high for exactly one clock cycle, and it is high in the same cycle in which the conditioned level takes its new value. Downstream logic can use these strobes to act on a transition of the external signal without creating a clock from it. Every register is clocked on the rising edge of the one system clock and is cleared by a synchronous active-high reset.

With the default settings (two synchronizer stages, a filter window of 10 cycles), a change on the raw input reaches the conditioned level 12 clock cycles after the first clock edge that samples it. At a 50 MHz clock, any excursion that lasts fewer than about ten clock periods (roughly 200 ns) is rejected.

Top module: `input_conditioner`

## Requirements
- R1: The raw input passes through SYNC_STAGES (default 2) cascaded flip-flops before any other logic uses it. The synchronized signal equals the raw input as sampled SYNC_STAGES clock edges earlier.
- R2: The conditioned level takes a new value only after the synchronized signal has differed from the current level on WAIT_CYCLES (default 10) consecutive clock edges. It changes on the last of those edges. A raw change first sampled at clock edge 1 therefore appears on `level_out` after edge WAIT_CYCLES+2.
- R3: A raw excursion that lasts fewer than WAIT_CYCLES clock cycles leaves `level_out` unchanged and produces no strobe on either `rise_out` or `fall_out`.
- R4: A single cycle in which the synchronized signal equals the current level restarts the stability count. Two excursions, each shorter than WAIT_CYCLES and separated by such a cycle, are both rejected, even though together they are longer than WAIT_CYCLES.
- R5: `rise_out` is high for exactly one clock cycle for each 0-to-1 transition of `level_out`, and it is high in the same cycle in which `level_out` first reads 1.
- R6: `fall_out` is high for exactly one clock cycle for each 1-to-0 transition of `level_out`, and it is high in the same cycle in which `level_out` first reads 0. `rise_out` and `fall_out` are never high together.
- R7: While `rst` is high on a clock edge, all registers are cleared: `level_out`, `rise_out` and `fall_out` read 0 whatever the raw input is doing. Neither reset nor its release produces an edge strobe.
- R8: The stability counter is sized from WAIT_CYCLES and stops at its terminal count. A raw level held far longer than WAIT_CYCLES produces exactly one strobe, and no further strobes follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Asynchronous external signal to be conditioned |
| level_out | output | 1 | Debounced, synchronized level |
| rise_out | output | 1 | One-cycle strobe on a 0-to-1 change of `level_out` |
| fall_out | output | 1 | One-cycle strobe on a 1-to-0 change of `level_out` |

## Verification
Long steady holds of each polarity show that an accepted change yields one strobe of the right kind and no more. Holds of exactly WAIT_CYCLES-1 and exactly WAIT_CYCLES cycles bound the acceptance threshold from both sides. A split bounce, two short runs joined by a one-cycle return, tells apart a counter that restarts from one that merely pauses. A cycle-by-cycle trace after a single raw change pins the latency through the synchronizer and the filter, and confirms that each strobe coincides with its level change. Resets applied with the raw input high, and again with the level already at 1, confirm that reset clears the outputs and that its release produces no strobe.

// File: rtl/cond_pkg.sv
package cond_pkg;

  // Width needed to hold counts 0 .. wait_cycles
  function automatic int cnt_width(input int wait_cycles);
    return (wait_cycles < 1) ? 1 : $clog2(wait_cycles + 1);
  endfunction

  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_t;

endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cond_debounce.sv
module cond_debounce #(
  parameter int WAIT_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic level_q,
  output logic level_d
);
  localparam int CNT_W = cond_pkg::cnt_width(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    if (sync_in == level_q) begin
      cnt_d = '0;
    end else if (cnt_q >= LAST) begin
      level_d = sync_in;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/cond_edge.sv
module cond_edge (
  input  logic              clk,
  input  logic              rst,
  input  logic              level_q,
  input  logic              level_d,
  output cond_pkg::strobe_t strobe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= '0;
    end else begin
      strobe_q.rise <= level_d & ~level_q;
      strobe_q.fall <= ~level_d & level_q;
    end
  end
endmodule

// File: rtl/input_conditioner.sv
module input_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic level_out,
  output logic rise_out,
  output logic fall_out
);
  logic              sync_w;
  logic              lvl_q;
  logic              lvl_d;
  cond_pkg::strobe_t strb;

  cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_w)
  );

  cond_debounce #(.WAIT_CYCLES(WAIT_CYCLES)) u_deb (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_w),
    .level_q (lvl_q),
    .level_d (lvl_d)
  );

  cond_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_q  (lvl_q),
    .level_d  (lvl_d),
    .strobe_q (strb)
  );

  assign level_out = lvl_q;
  assign rise_out  = strb.rise;
  assign fall_out  = strb.fall;
endmodule

// File: rtl/input_conditioner_chk.sv
module input_conditioner_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 10
) (
  input logic clk,
  input logic rst,
  input logic raw,
  input logic sync,
  input logic level,
  input logic rise,
  input logic fall
);
  logic [1:0] since_q;
  int         run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= 2'd0;
      run_q   <= 0;
    end else begin
      if (since_q != 2'd2) since_q <= since_q + 2'd1;
      if (sync == level) run_q <= 0;
      else if (run_q < WAIT_CYCLES) run_q <= run_q + 1;
    end
  end

  // R1
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (SYNC_STAGES == 2 && since_q == 2'd2) |-> (sync == $past(raw, 2)));

  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since_q != 2'd0 && level != $past(level)) |-> ($past(run_q) >= WAIT_CYCLES - 1));

  // R2
  level_take_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q == WAIT_CYCLES - 1 && sync != level) |=> (level == $past(sync)));

  // R5
  rise_match_chk: assert property (@(posedge clk) disable iff (rst)
    (since_q != 2'd0 && $rose(level)) |-> rise);

  // R5
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> $rose(level));

  // R6
  fall_match_chk: assert property (@(posedge clk) disable iff (rst)
    (since_q != 2'd0 && $fell(level)) |-> fall);

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    fall |-> $fell(level));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));
endmodule

bind input_conditioner input_conditioner_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .raw   (raw_in),
  .sync  (sync_w),
  .level (level_out),
  .rise  (rise_out),
  .fall  (fall_out)
);

// File: tb/input_conditioner_test.sv
`timescale 1ns/1ps
module input_conditioner_test;
  localparam int WAIT = 10;
  localparam int N    = 11;

  // stimulus: raw value, hold cycles; expected: level, rise count, fall count
  localparam int T_RAW  [N] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam int T_HOLD [N] = '{20, 9, 20, 20, 5, 1, 9, 20, 10, 30, 40};
  localparam int T_LVL  [N] = '{1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam int T_RISE [N] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int T_FALL [N] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0};
  localparam string T_TAG [N] = '{"R2/R5", "R3", "R3", "R2/R6", "R4", "R4",
                                  "R4", "R4", "R2", "R2/R5/R6", "R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic level, rise, fall;
  int   n_checks = 0;
  int   n_fail   = 0;
  int   rise_cnt, fall_cnt;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  input_conditioner #(.SYNC_STAGES(2), .WAIT_CYCLES(WAIT)) uut (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw),
    .level_out (level),
    .rise_out  (rise),
    .fall_out  (fall)
  );

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
    end
  endtask

  // advance one clock edge, then sample away from it
  task automatic step();
    @(posedge clk);
    #1;
    if (rise) rise_cnt++;
    if (fall) fall_cnt++;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R7: reset holds everything at zero even with raw high
    raw = 1'b1;
    rise_cnt = 0; fall_cnt = 0;
    for (int i = 0; i < 4; i++) step();
    check("R7 level in reset", level, 0);
    check("R7 strobes in reset", rise_cnt + fall_cnt, 0);
    raw = 1'b0;
    rst = 1'b0;
    rise_cnt = 0; fall_cnt = 0;
    for (int i = 0; i < 20; i++) step();
    check("R7 level after release", level, 0);
    check("R7 no strobe after release", rise_cnt + fall_cnt, 0);

    // vector table
    for (int e = 0; e < N; e++) begin
      rise_cnt = 0; fall_cnt = 0;
      raw = T_RAW[e][0];
      for (int c = 0; c < T_HOLD[e]; c++) step();
      check({T_TAG[e], " level"}, level, T_LVL[e]);
      check({T_TAG[e], " rise count"}, rise_cnt, T_RISE[e]);
      check({T_TAG[e], " fall count"}, fall_cnt, T_FALL[e]);
    end

    // R1/R2/R6: exact latency of a falling change (level is 1 here)
    raw = 1'b0;
    for (int i = 1; i <= WAIT + 3; i++) begin
      step();
      if (i == WAIT + 1) begin
        check("R1/R2 level before latency", level, 1);
        check("R6 no early fall", fall, 0);
      end
      if (i == WAIT + 2) begin
        check("R1/R2 level at latency", level, 0);
        check("R6 fall with level", fall, 1);
      end
      if (i == WAIT + 3) check("R6 fall one cycle", fall, 0);
    end

    // R1/R2/R5: exact latency of a rising change
    raw = 1'b1;
    for (int i = 1; i <= WAIT + 3; i++) begin
      step();
      if (i == WAIT + 1) check("R2 level before latency", level, 0);
      if (i == WAIT + 2) begin
        check("R2 level at latency", level, 1);
        check("R5 rise with level", rise, 1);
      end
      if (i == WAIT + 3) check("R5 rise one cycle", rise, 0);
    end

    // R7: reset with level at 1 clears without a strobe
    rise_cnt = 0; fall_cnt = 0;
    rst = 1'b1;
    raw = 1'b0;
    step();
    step();
    check("R7 level cleared", level, 0);
    check("R7 no strobe on reset", rise_cnt + fall_cnt, 0);
    rst = 1'b0;
    for (int i = 0; i < 30; i++) step();
    check("R7 level stays low", level, 0);
    check("R7 no strobe after reset", rise_cnt + fall_cnt, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule